// File: doc/BRIEF.md
# Ratio Divider Coincidence Sync Generator

This block divides a single fast reference clock into two clock groups, A and C, each with its own programmable integer divisor. By picking the two divisors, the frequency ratio between the groups can be set to integer relations such as 2:1 or 6:1. It can also be set to fractional relations such as 3:2, 4:3, 5:3 or 6:5. Odd divisors are supported, so each group can run at an odd or even fraction of the reference.

The rising edges of the two groups line up once every least-common-multiple of the two divisors. An active-low sync output goes low for one fast clock cycle just before each of those shared rising edges. Logic downstream can use it to transfer data between the two domains at a known safe point.

A synchronous reset restarts both groups so that their first rising edges coincide. A change of divisor takes effect only at a reset or at the next shared edge, so no shortened period appears on either output.

Top module: `ratio_sync_gen`

## Requirements
- R1: While `rst` is high, `clkA` and `clkC` are low and `syncN` is high. At the first fast clock edge after `rst` is sampled low, both `clkA` and `clkC` rise together.
- R2: The divisor of each group equals its 4-bit select code (`selA` for A, `selC` for C), over the range 2 to 12. The frequency ratio A:C equals divisor C : divisor A. Over one super-period of lcm(divA, divC) fast cycles, A rises lcm/divA times and C rises lcm/divC times. This covers the ratios 1:1, 2:1, 3:1, 3:2, 4:1, 4:3, 5:1, 5:2, 5:3, 6:1 and 6:5.
- R3: With an even divisor d, a group output is high for d/2 fast cycles and then low for d/2 fast cycles.
- R4: With an odd divisor d, a group output is high for floor(d/2) fast cycles and then low for the remaining ceil(d/2) fast cycles.
- R5: `syncN` is active low. It goes low at the fast clock edge just before a shared rising edge of `clkA` and `clkC`, and goes high again at that shared edge, so each low pulse lasts exactly one fast cycle.
- R6: After the first shared edge that follows reset, `syncN` pulses for every shared rising edge and at no other time. Shared edges repeat every lcm(divA, divC) fast cycles.
- R7: A new select code is sampled only during reset or at the edge that starts a new super-period. Until then, both groups keep their current divisors.
- R8: A select code of 0 or 1 is treated as a divisor of 2. A code above 12 is treated as a divisor of 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| selA | input | 4 | Divisor select code for group A |
| selC | input | 4 | Divisor select code for group C |
| clkA | output | 1 | Divided clock, group A |
| clkC | output | 1 | Divided clock, group C |
| syncN | output | 1 | Active-low pulse one fast edge before each shared rising edge |

## Verification
The bench builds the block with its default maximum divisor of 12, so the select codes are 4 bits wide. This keeps an exhaustive sweep small: every one of the 121 divisor pairs from 2 to 12 runs for two full super-periods. That includes every listed ratio and every odd/even combination, and each cycle is compared against an arithmetic model. The five out-of-range codes are also driven to exercise clamping. A select change in the middle of a super-period checks that the old divisors persist until the next shared edge.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int unsigned NUM_GROUPS = 2;
  localparam int unsigned GRP_A = 0;
  localparam int unsigned GRP_C = 1;

  typedef struct packed {
    logic reload;   // super-period boundary: both groups wrap, sample new selects
  } rdc_strobe_t;
endpackage

// File: rtl/rdc_group_counter.sv
module rdc_group_counter #(
  parameter int MAX_DIV = 12,
  localparam int SEL_W = $clog2(MAX_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic [SEL_W-1:0] selCode,
  output logic             divClk,
  output logic             atLast
);
  localparam logic [SEL_W-1:0] MIN_SEL = SEL_W'(2);
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(MAX_DIV);

  logic [SEL_W-1:0] divReg;
  logic [SEL_W-1:0] cnt;
  logic [SEL_W-1:0] halfDiv;

  function automatic logic [SEL_W-1:0] clampSel(input logic [SEL_W-1:0] s);
    if (s < MIN_SEL) return MIN_SEL;
    if (s > MAX_SEL) return MAX_SEL;
    return s;
  endfunction

  assign halfDiv = divReg >> 1;
  assign atLast  = (cnt == divReg - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      divClk <= 1'b0;
      divReg <= clampSel(selCode);
    end else begin
      divClk <= (cnt < halfDiv);
      if (atLast) cnt <= '0;
      else        cnt <= cnt + 1'b1;
      if (reload) divReg <= clampSel(selCode);
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < divReg);
  assert_div_clamp_R8: assert property (@(posedge clk) disable iff (rst)
    (divReg >= MIN_SEL) && (divReg <= MAX_SEL));
  assert_rise_phase_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(divClk) |-> (cnt == SEL_W'(1)));
  assert_select_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(divReg));
endmodule

// File: rtl/rdc_datapath.sv
module rdc_datapath
  import rdc_pkg::*;
#(
  parameter int MAX_DIV = 12,
  localparam int SEL_W = $clog2(MAX_DIV + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  rdc_strobe_t           strobe,
  input  logic [SEL_W-1:0]      selCode [NUM_GROUPS],
  output logic [NUM_GROUPS-1:0] divClk,
  output logic [NUM_GROUPS-1:0] atLast
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_group
    rdc_group_counter #(.MAX_DIV(MAX_DIV)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .reload (strobe.reload),
      .selCode(selCode[g]),
      .divClk (divClk[g]),
      .atLast (atLast[g])
    );
  end
endmodule

// File: rtl/rdc_ctrl.sv
module rdc_ctrl
  import rdc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_GROUPS-1:0] atLast,
  output rdc_strobe_t           strobe,
  output logic                  syncN
);
  logic coincNext;

  // every group on its final count: all wrap together on the coming edge
  assign coincNext     = &atLast;
  assign strobe.reload = coincNext;

  always_ff @(posedge clk) begin
    if (rst) syncN <= 1'b1;
    else     syncN <= !coincNext;
  end

  assert_sync_single_R5: assert property (@(posedge clk) disable iff (rst)
    !syncN |=> syncN);
endmodule

// File: rtl/ratio_sync_gen.sv
module ratio_sync_gen
  import rdc_pkg::*;
#(
  parameter int MAX_DIV = 12,
  localparam int SEL_W = $clog2(MAX_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] selA,
  input  logic [SEL_W-1:0] selC,
  output logic             clkA,
  output logic             clkC,
  output logic             syncN
);
  rdc_strobe_t           strobe;
  logic [SEL_W-1:0]      selArr [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] divClk;
  logic [NUM_GROUPS-1:0] atLast;

  assign selArr[GRP_A] = selA;
  assign selArr[GRP_C] = selC;

  rdc_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .atLast(atLast),
    .strobe(strobe),
    .syncN (syncN)
  );

  rdc_datapath #(.MAX_DIV(MAX_DIV)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .selCode(selArr),
    .divClk (divClk),
    .atLast (atLast)
  );

  assign clkA = divClk[GRP_A];
  assign clkC = divClk[GRP_C];

  assert_sync_lead_R5: assert property (@(posedge clk) disable iff (rst)
    !syncN |=> ($rose(clkA) && $rose(clkC)));
  assert_coinc_flagged_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(clkA) && $rose(clkC) && !$past(rst, 2)) |-> !$past(syncN));
endmodule

// File: tb/ratio_sync_gen_tb.sv
`timescale 1ns/1ps
module ratio_sync_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] selA = 4'd2;
  logic [3:0] selC = 4'd2;
  logic clkA, clkC, syncN;

  int checks = 0;
  int errors = 0;
  int mA, mC, effA, effC;

  always #2 clk = ~clk;

  ratio_sync_gen u_dut (
    .clk(clk), .rst(rst), .selA(selA), .selC(selC),
    .clkA(clkA), .clkC(clkC), .syncN(syncN)
  );

  function automatic int clampI(input int s);
    if (s < 2) return 2;
    if (s > 12) return 12;
    return s;
  endfunction

  function automatic int lcmI(input int a, input int b);
    int x = a;
    int y = b;
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return (a / x) * b;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one fast cycle: model predicts outputs after the coming edge, then compare
  task automatic tick(input string ovr);
    int expA, expC, expS;
    bit wrap;
    string tA, tC, tS;
    if (rst) begin
      expA = 0; expC = 0; expS = 1;
      effA = clampI(selA); effC = clampI(selC);
      mA = 0; mC = 0;
      tA = "R1"; tC = "R1"; tS = "R1";
    end else begin
      expA = (mA < effA / 2) ? 1 : 0;
      expC = (mC < effC / 2) ? 1 : 0;
      wrap = (mA == effA - 1) && (mC == effC - 1);
      expS = wrap ? 0 : 1;
      tA = (effA % 2 == 1) ? "R4" : "R3";
      tC = (effC % 2 == 1) ? "R4" : "R3";
      tS = "R5";
      if (wrap) begin
        effA = clampI(selA); effC = clampI(selC);
        mA = 0; mC = 0;
      end else begin
        mA = (mA + 1) % effA;
        mC = (mC + 1) % effC;
      end
    end
    if (ovr != "") begin tA = ovr; tC = ovr; end
    @(posedge clk);
    @(negedge clk);
    chk(tA, "clkA", clkA, expA);
    chk(tC, "clkC", clkC, expC);
    chk(tS, "syncN", syncN, expS);
  endtask

  task automatic doReset(input string ovr);
    rst = 1'b1;
    tick(ovr);
    tick(ovr);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // exhaustive divisor pair sweep (R2, R3, R4, R5, R6)
    for (int a = 2; a <= 12; a++) begin
      for (int c = 2; c <= 12; c++) begin
        int lcm, risesA, risesC, syncLows, prevA, prevC;
        selA = 4'(a); selC = 4'(c);
        doReset("");
        lcm = lcmI(a, c);
        risesA = 0; risesC = 0; syncLows = 0;
        prevA = clkA; prevC = clkC;
        for (int k = 1; k <= 2 * lcm + 1; k++) begin
          tick("");
          if (k == 1) chk("R1", "both rise after reset", int'(clkA && clkC), 1);
          if (k <= lcm) begin
            if (clkA && prevA == 0) risesA++;
            if (clkC && prevC == 0) risesC++;
          end
          if (!syncN) syncLows++;
          prevA = clkA; prevC = clkC;
        end
        chk("R2", $sformatf("A rises per lcm a=%0d c=%0d", a, c), risesA, lcm / a);
        chk("R2", $sformatf("C rises per lcm a=%0d c=%0d", a, c), risesC, lcm / c);
        chk("R6", $sformatf("sync pulses a=%0d c=%0d", a, c), syncLows, 2);
      end
    end

    // out-of-range codes clamp (R8)
    for (int code = 0; code < 16; code++) begin
      if (code >= 2 && code <= 12) continue;
      selA = 4'(code); selC = 4'd3;
      doReset("R8");
      for (int k = 0; k < 2 * lcmI(clampI(code), 3) + 2; k++) tick("R8");
    end

    // select change mid super-period (R7)
    selA = 4'd2; selC = 4'd3;
    doReset("R7");
    tick("R7"); tick("R7");
    selA = 4'd5;
    for (int k = 0; k < 8; k++) tick("R7");
    selC = 4'd4;
    for (int k = 0; k < 50; k++) tick("R7");
    selA = 4'd7; selC = 4'd6;
    for (int k = 0; k < 100; k++) tick("R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule